// File: doc/BRIEF.md
# ECC Error Capture Register Block

This block sits beside a DRAM datapath and keeps a record of the faults that the datapath reports. The datapath pulses a corrected-error strobe or an uncorrectable-error strobe. With each pulse it supplies the full error address, the channel number and the 8-bit ECC syndrome. Three further one-cycle strobes report a refresh timeout, a locked access that targeted non-DRAM memory, and a thermal sensor trip. Each event sets a sticky flag in a 16-bit status register. Software clears a flag by writing a one to it.

The first ECC error is captured along with its context: the address at 128-byte granularity, the channel and the syndrome. Software reads this through a small register port that has a selector, a write strobe and write data, and returns read data combinationally. An uncorrectable error has priority over a corrected error that is already logged, so the more serious event is always the one whose context is kept.

A 16-bit command register holds one enable for each status condition. The block drives a registered system-error output whenever an enabled condition is pending.

Top module: `ecc_err_log`

## Requirements
- R1: Status (selector 0) flags a corrected error in bit 0, an uncorrectable error in bit 1, a refresh timeout in bit 8, a locked non-DRAM access in bit 9 and a thermal event in bit 11. All other bits read zero. Every register reads zero after reset.
- R2: An event strobe that is high at a clock edge sets its status flag at that edge. The flag stays set until it is cleared.
- R3: A write to selector 0 clears every status flag whose write-data bit is one and leaves the others unchanged. If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R4: The pointer register (selector 2) returns error address bits 31:7 in bits 31:7, zero in bits 6:1, and the channel in bit 0.
- R5: The extended register (selector 3) returns error address bit 32 in bit 0. All higher bits read zero.
- R6: The syndrome register (selector 4) returns the 8-bit syndrome of the logged error in bits 7:0. A corrected error that arrives while neither ECC flag is set captures its address, channel and syndrome.
- R7: An uncorrectable error that arrives while the uncorrectable flag is clear captures its address, channel and syndrome. This holds even when a corrected error is already logged, and in that case both flags remain set. When both strobes are high in the same cycle, the uncorrectable error's context is the one kept.
- R8: A corrected error that arrives while either ECC flag is set does not change the logged context. An uncorrectable error that arrives while the uncorrectable flag is set does not change it either.
- R9: The command register (selector 1) can be read and written in bits 0, 1, 8, 9 and 11, and its other bits read zero. Writes to selectors 2, 3 and 4 have no effect. Selectors 5 to 7 read zero.
- R10: sys_err equals the OR, over all bits, of status AND command, registered once. It therefore changes one cycle after the status or command register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_evt | input | 1 | Corrected (single-bit) ECC error strobe |
| ue_evt | input | 1 | Uncorrectable (multi-bit) ECC error strobe |
| evt_addr | input | ADDR_W (33) | Byte address of the reported error |
| evt_chan | input | 1 | Channel of the reported error |
| evt_syn | input | SYN_W (8) | ECC syndrome of the reported error |
| rfsh_evt | input | 1 | Refresh timeout strobe |
| lock_evt | input | 1 | Locked access to non-DRAM memory strobe |
| therm_evt | input | 1 | Thermal sensor event strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | SEL_W (3) | Register selector |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for the selected register |
| sys_err | output | 1 | Registered system-error indication |

## Verification
On every cycle, the assertions check the following: event strobes set their flags, a one-write clears a flag when no event competes for it, reserved status bits read zero, the command register takes each write, the uncorrectable-error capture happens, a held context stays frozen, and sys_err tracks status AND command with a one-cycle lag. The bench scenarios are needed for the behaviour that depends on sequences. These are a corrected error followed by an overwriting uncorrectable one, a second error of each kind being rejected, a simultaneous clear and set, writes to the read-only registers, and the pointer and extended-register field layout for specific addresses.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
   localparam int STAT_W  = 16;
   localparam int B_CE    = 0;
   localparam int B_UE    = 1;
   localparam int B_RFSH  = 8;
   localparam int B_LOCK  = 9;
   localparam int B_THERM = 11;
   localparam logic [STAT_W-1:0] STAT_MASK =
      STAT_W'((1 << B_CE) | (1 << B_UE) | (1 << B_RFSH) | (1 << B_LOCK) | (1 << B_THERM));

   localparam int SEL_STAT = 0;
   localparam int SEL_CMD  = 1;
   localparam int SEL_PTR  = 2;
   localparam int SEL_EXT  = 3;
   localparam int SEL_SYN  = 4;
endpackage

// File: rtl/ecc_log_status.sv
module ecc_log_status
   import ecc_log_pkg::*;
#(
   parameter int W = STAT_W,
   parameter logic [W-1:0] MASK = STAT_MASK
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] flags
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags[i] <= 1'b0;
            else if (set_vec[i]) flags[i] <= 1'b1;
            else if (clr_vec[i]) flags[i] <= 1'b0;
         end
      end else begin : g_rsvd
         assign flags[i] = 1'b0;
         wire unused_bit = set_vec[i] ^ clr_vec[i];
      end
   end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
   parameter int ADDR_W    = 33,
   parameter int GRAIN_LSB = 7,
   parameter int SYN_W     = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        ce_evt,
   input  logic                        ue_evt,
   input  logic                        ce_held,
   input  logic                        ue_held,
   input  logic [ADDR_W-1:0]           evt_addr,
   input  logic                        evt_chan,
   input  logic [SYN_W-1:0]            evt_syn,
   output logic [ADDR_W-1:GRAIN_LSB]   addr_q,
   output logic                        chan_q,
   output logic [SYN_W-1:0]            syn_q
);
   logic take_ue, take_ce, load;
   wire  unused_lsb = ^evt_addr[GRAIN_LSB-1:0];

   assign take_ue = ue_evt && !ue_held;
   assign take_ce = ce_evt && !ce_held && !ue_held;
   assign load    = take_ue || take_ce;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         chan_q <= 1'b0;
         syn_q  <= '0;
      end else if (load) begin
         addr_q <= evt_addr[ADDR_W-1:GRAIN_LSB];
         chan_q <= evt_chan;
         syn_q  <= evt_syn;
      end
   end
endmodule

// File: rtl/ecc_log_regif.sv
module ecc_log_regif
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W    = 33,
   parameter int GRAIN_LSB = 7,
   parameter int SYN_W     = 8,
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [SEL_W-1:0]          reg_sel,
   input  logic [DATA_W-1:0]         reg_wdata,
   input  logic [STAT_W-1:0]         stat,
   input  logic [ADDR_W-1:GRAIN_LSB] addr_q,
   input  logic                      chan_q,
   input  logic [SYN_W-1:0]          syn_q,
   output logic [STAT_W-1:0]         cmd_q,
   output logic [STAT_W-1:0]         clr_vec,
   output logic [DATA_W-1:0]         reg_rdata
);
   localparam int EXT_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] ptr_word, ext_word;
   logic              wr_stat, wr_cmd;
   wire               unused_hi = ^reg_wdata[DATA_W-1:STAT_W];

   assign wr_stat = reg_wr && (int'(reg_sel) == SEL_STAT);
   assign wr_cmd  = reg_wr && (int'(reg_sel) == SEL_CMD);
   assign clr_vec = wr_stat ? (reg_wdata[STAT_W-1:0] & STAT_MASK) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmd_q <= '0;
      else if (wr_cmd) cmd_q <= reg_wdata[STAT_W-1:0] & STAT_MASK;
   end

   assign ptr_word = {addr_q[DATA_W-1:GRAIN_LSB], {(GRAIN_LSB-1){1'b0}}, chan_q};
   assign ext_word = {{(DATA_W-EXT_W){1'b0}}, addr_q[ADDR_W-1:DATA_W]};

   always_comb begin
      case (int'(reg_sel))
         SEL_STAT: reg_rdata = DATA_W'(stat);
         SEL_CMD:  reg_rdata = DATA_W'(cmd_q);
         SEL_PTR:  reg_rdata = ptr_word;
         SEL_EXT:  reg_rdata = ext_word;
         SEL_SYN:  reg_rdata = DATA_W'(syn_q);
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
   import ecc_log_pkg::*;
#(
   parameter int ADDR_W    = 33,
   parameter int GRAIN_LSB = 7,
   parameter int SYN_W     = 8,
   parameter int DATA_W    = 32,
   parameter int SEL_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_evt,
   input  logic              ue_evt,
   input  logic [ADDR_W-1:0] evt_addr,
   input  logic              evt_chan,
   input  logic [SYN_W-1:0]  evt_syn,
   input  logic              rfsh_evt,
   input  logic              lock_evt,
   input  logic              therm_evt,
   input  logic              reg_wr,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sys_err
);
   if (ADDR_W <= DATA_W || ADDR_W - DATA_W > 8) begin : g_bad_addr
      $error("ADDR_W must exceed DATA_W by 1 to 8 bits");
   end
   if (GRAIN_LSB < 2 || GRAIN_LSB >= DATA_W) begin : g_bad_grain
      $error("GRAIN_LSB out of range");
   end
   if (SYN_W > DATA_W || DATA_W < STAT_W) begin : g_bad_width
      $error("SYN_W or DATA_W out of range");
   end
   if ((1 << SEL_W) <= SEL_SYN) begin : g_bad_sel
      $error("SEL_W too narrow for the register map");
   end

   logic [STAT_W-1:0]         set_vec, clr_vec, stat_q, cmd_q;
   logic [ADDR_W-1:GRAIN_LSB] addr_q;
   logic                      chan_q;
   logic [SYN_W-1:0]          syn_q;
   logic                      sys_err_q;

   always_comb begin
      set_vec          = '0;
      set_vec[B_CE]    = ce_evt;
      set_vec[B_UE]    = ue_evt;
      set_vec[B_RFSH]  = rfsh_evt;
      set_vec[B_LOCK]  = lock_evt;
      set_vec[B_THERM] = therm_evt;
   end

   ecc_log_status #(.W(STAT_W), .MASK(STAT_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(stat_q)
   );

   ecc_log_capture #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
      .ce_held(stat_q[B_CE]), .ue_held(stat_q[B_UE]),
      .evt_addr(evt_addr), .evt_chan(evt_chan), .evt_syn(evt_syn),
      .addr_q(addr_q), .chan_q(chan_q), .syn_q(syn_q)
   );

   ecc_log_regif #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W),
                   .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rif (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .stat(stat_q), .addr_q(addr_q), .chan_q(chan_q),
      .syn_q(syn_q), .cmd_q(cmd_q), .clr_vec(clr_vec), .reg_rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sys_err_q <= 1'b0;
      else        sys_err_q <= |(stat_q & cmd_q);
   end
   assign sys_err = sys_err_q;
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
   import ecc_log_pkg::*;
#(
   parameter int SYN_W  = 8,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_evt,
   input logic              ue_evt,
   input logic              lock_evt,
   input logic              therm_evt,
   input logic [SYN_W-1:0]  evt_syn,
   input logic              evt_chan,
   input logic              reg_wr,
   input logic [SEL_W-1:0]  reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [STAT_W-1:0] stat_q,
   input logic [STAT_W-1:0] cmd_q,
   input logic [SYN_W-1:0]  syn_q,
   input logic              chan_q,
   input logic              sys_err
);
   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_sel) == SEL_STAT) |-> ((reg_rdata & ~DATA_W'(STAT_MASK)) == '0));

   p_ce_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ce_evt |=> stat_q[B_CE]);

   p_therm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      therm_evt |=> stat_q[B_THERM]);

   p_w1c_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_sel) == SEL_STAT && reg_wdata[B_LOCK] && !lock_evt)
      |=> !stat_q[B_LOCK]);

   p_ue_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && !stat_q[B_UE]) |=> (syn_q == $past(evt_syn) && chan_q == $past(evt_chan)));

   p_hold_ctx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q[B_CE] || stat_q[B_UE]) && !(ue_evt && !stat_q[B_UE]))
      |=> ($stable(syn_q) && $stable(chan_q)));

   p_cmd_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && int'(reg_sel) == SEL_CMD)
      |=> (cmd_q == ($past(reg_wdata[STAT_W-1:0]) & STAT_MASK)));

   p_serr_lag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (sys_err == |($past(stat_q) & $past(cmd_q))));
endmodule

bind ecc_err_log ecc_err_log_chk #(.SYN_W(SYN_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt), .lock_evt(lock_evt),
   .therm_evt(therm_evt), .evt_syn(evt_syn), .evt_chan(evt_chan), .reg_wr(reg_wr),
   .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stat_q(stat_q),
   .cmd_q(cmd_q), .syn_q(syn_q), .chan_q(chan_q), .sys_err(sys_err)
);

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;
   localparam logic [15:0] MASK = 16'h0B03;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_evt = 0, ue_evt = 0, rfsh_evt = 0, lock_evt = 0, therm_evt = 0;
   logic [32:0] evt_addr = '0;
   logic        evt_chan = 0;
   logic [7:0]  evt_syn = '0;
   logic        reg_wr = 0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sys_err;

   int total = 0, fails = 0;
   bit done = 0;

   logic [15:0] m_stat = '0, m_cmd = '0;
   logic [32:0] m_addr = '0;
   logic        m_chan = 0, m_serr = 0;
   logic [7:0]  m_syn = '0;

   always #4 clk = ~clk;

   ecc_err_log u0 (
      .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt), .evt_addr(evt_addr),
      .evt_chan(evt_chan), .evt_syn(evt_syn), .rfsh_evt(rfsh_evt), .lock_evt(lock_evt),
      .therm_evt(therm_evt), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sys_err(sys_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int sel);
      case (sel)
         0: return {16'h0, m_stat};
         1: return {16'h0, m_cmd};
         2: return {m_addr[31:7], 6'b0, m_chan};
         3: return {31'b0, m_addr[32]};
         4: return {24'b0, m_syn};
         default: return 32'h0;
      endcase
   endfunction

   // reads every selector combinationally, then checks sys_err
   task automatic check_all();
      string tags [8] = '{"R1 R2 R3 status", "R9 command", "R4 pointer", "R5 extended",
                          "R6 syndrome", "R9 sel5", "R9 sel6", "R9 sel7"};
      for (int s = 0; s < 8; s++) begin
         reg_sel = 3'(s);
         #0.1;
         chk(tags[s], reg_rdata, exp_read(s));
      end
      chk("R10 sys_err", {31'b0, sys_err}, {31'b0, m_serr});
   endtask

   // drives one cycle of stimulus, updates the model, checks after the edge
   task automatic step(input logic ce, ue, rf, lk, th, wr, input logic [2:0] sel,
                       input logic [31:0] wd, input logic [32:0] a, input logic ch,
                       input logic [7:0] sy);
      logic [15:0] setv, clrv, old;
      ce_evt = ce; ue_evt = ue; rfsh_evt = rf; lock_evt = lk; therm_evt = th;
      reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      evt_addr = a; evt_chan = ch; evt_syn = sy;
      m_serr = |(m_stat & m_cmd);
      old = m_stat;
      if ((ue && !old[1]) || (ce && !old[0] && !old[1])) begin   // R6 R7 R8
         m_addr = a; m_chan = ch; m_syn = sy;
      end
      setv = '0;
      setv[0] = ce; setv[1] = ue; setv[8] = rf; setv[9] = lk; setv[11] = th;
      clrv = (wr && sel == 3'd0) ? (wd[15:0] & MASK) : 16'h0;
      m_stat = setv | (old & ~clrv);
      if (wr && sel == 3'd1) m_cmd = wd[15:0] & MASK;
      @(posedge clk);
      @(negedge clk);
      ce_evt = 0; ue_evt = 0; rfsh_evt = 0; lock_evt = 0; therm_evt = 0; reg_wr = 0;
      check_all();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #1600000;
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check_all();                         // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R9 command write of all ones keeps only defined bits
      step(0,0,0,0,0, 1, 3'd1, 32'hFFFF_FFFF, '0, 0, 8'h00);
      // R6 first corrected error captured; R4 R5 layout
      step(1,0,0,0,0, 0, 3'd0, 32'h0, 33'h1_2345_67FF, 1, 8'h5A);
      chk("R4 pointer value", exp_read(2), 32'h2345_6781);
      // R8 second corrected error ignored
      step(1,0,0,0,0, 0, 3'd0, 32'h0, 33'h0_0000_1000, 0, 8'h11);
      // R7 uncorrectable overwrites a logged corrected error
      step(0,1,0,0,0, 0, 3'd0, 32'h0, 33'h0_ABCD_EF80, 0, 8'hC3);
      // R8 second uncorrectable ignored
      step(0,1,0,0,0, 0, 3'd0, 32'h0, 33'h1_FFFF_FFFF, 1, 8'hEE);
      // R9 writes to read-only registers have no effect
      step(0,0,0,0,0, 1, 3'd2, 32'hFFFF_FFFF, '0, 0, 8'h00);
      step(0,0,0,0,0, 1, 3'd4, 32'hFFFF_FFFF, '0, 0, 8'h00);
      // R3 clear all while a corrected error arrives: set wins on bit 0
      step(1,0,1,0,0, 1, 3'd0, 32'h0000_0B03, 33'h0_0000_0080, 1, 8'h01);
      // R3 writing zeros leaves flags
      step(0,0,0,1,1, 0, 3'd0, 32'h0, '0, 0, 8'h00);
      step(0,0,0,0,0, 1, 3'd0, 32'h0, '0, 0, 8'h00);
      // R7 simultaneous strobes after a clean clear: uncorrectable context kept
      step(0,0,0,0,0, 1, 3'd0, 32'hFFFF, '0, 0, 8'h00);
      step(1,1,0,0,0, 0, 3'd0, 32'h0, 33'h1_0000_0100, 1, 8'h77);
      // R10 command cleared drops sys_err a cycle later
      step(0,0,0,0,0, 1, 3'd1, 32'h0, '0, 0, 8'h00);
      step(0,0,0,0,0, 0, 3'd0, 32'h0, '0, 0, 8'h00);

      // random phase covering R1 to R10 together
      for (int i = 0; i < 3000; i++) begin
         logic wr;
         logic [2:0] sel;
         logic [31:0] wd;
         wr  = ($urandom_range(3) == 0);
         sel = 3'($urandom_range(7));
         wd  = $urandom();
         if (sel == 3'd0 && $urandom_range(1) == 0) wd = 32'($urandom_range(16'hFFFF));
         step($urandom_range(7) == 0, $urandom_range(15) == 0, $urandom_range(9) == 0,
              $urandom_range(9) == 0, $urandom_range(9) == 0, wr, sel, wd,
              {1'($urandom_range(1)), 32'($urandom())}, 1'($urandom_range(1)),
              8'($urandom_range(255)));
      end
      done = 1;
      summary();
   end
endmodule